// File: doc/BRIEF.md
# Dual-Read Register File with Same-Cycle Write Forwarding

This block is the architectural register store of a five-stage processor. In each clock cycle the decode stage presents two register numbers and gets their contents back on two independent read ports. In the same cycle the writeback stage may present one register number, a value and an enable. The value is stored at the next rising clock edge.

A register that is written and read in the same cycle would otherwise give the decode stage a stale value. The block handles this by steering the incoming write value straight onto any read port whose number matches the write number. Each port makes this choice on its own. Register number zero is a constant zero: it ignores writes and is never forwarded. While the synchronous reset is high, the write port is disabled, and that includes forwarding.

Top module: `regfile_bypass`

## Requirements
- R1: The file holds DEPTH registers of DATA_W bits each (defaults 32 and 32), selected by register numbers of ADDR_W = clog2(DEPTH) bits.
- R2: Each read port returns, combinationally from its own register number, the stored contents of that register.
- R3: A write with `wb_en` = 1 and a nonzero `wb_addr` stores `wb_data` at the rising clock edge, and later reads of that register return it.
- R4: With `wb_en` = 1 and a nonzero `wb_addr` equal to a read port's number, that port returns `wb_data` in the same cycle, before the edge.
- R5: Register 0 always reads as zero. A write to register 0 is dropped, and it is not forwarded to a port that reads register 0.
- R6: Forwarding is decided per port. Both ports may forward in the same cycle, and a port whose number does not match reads its stored value.
- R7: With `wb_en` = 0, no register changes and no port forwards, even when the write number matches a read number.
- R8: While `rst` = 1, writes are neither stored nor forwarded. Registers written before reset keep their values through it.
- R9: The highest register number (DEPTH-1) is stored and forwarded like any other, independently of its neighbours.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst | input | 1 | Synchronous active-high reset; blocks the write port |
| rd_a_addr | input | ADDR_W | Register number for read port A |
| rd_a_data | output | DATA_W | Read port A data |
| rd_b_addr | input | ADDR_W | Register number for read port B |
| rd_b_data | output | DATA_W | Read port B data |
| wb_en | input | 1 | Write enable from writeback |
| wb_addr | input | ADDR_W | Register number to write |
| wb_data | input | DATA_W | Value to write |

## Verification
The bench builds the block with its default parameters: 32 registers of 32 bits and 5-bit register numbers. With these values, the top register 31 and its neighbour 30 can be reached, and register 0 can be exercised on both ports. Every read is sampled in the low phase of the clock, after the inputs change and before the next edge. This separates a forwarded value from a committed one, so forwarding on one port or both ports, stale reads with the enable low, and writes dropped during reset each give a different expected value.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int RF_DEPTH_DEF  = 32;
  localparam int RF_DATA_W_DEF = 32;

  // Source chosen for one read port
  typedef enum logic [1:0] {
    SRC_ARRAY = 2'd0,
    SRC_WRITE = 2'd1,
    SRC_ZERO  = 2'd2
  } rd_src_e;
endpackage

// File: rtl/rf_store.sv
module rf_store #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 32,
  parameter int NRD    = 2,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic [NRD*ADDR_W-1:0]   rd_addr,
  output logic [NRD*DATA_W-1:0]   rd_data
);
  // Plain array with one synchronous write port and asynchronous reads,
  // so the tools can map it onto distributed RAM.
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data[p*DATA_W +: DATA_W] = mem[rd_addr[p*ADDR_W +: ADDR_W]];
  end
endmodule

// File: rtl/rf_bypass.sv
module rf_bypass
  import rf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] stored,
  input  logic              wr_live,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  rd_src_e src;

  always_comb begin
    if (rd_addr == '0)                          src = SRC_ZERO;
    else if (wr_live && (wr_addr == rd_addr))   src = SRC_WRITE;
    else                                        src = SRC_ARRAY;
  end

  always_comb begin
    unique case (src)
      SRC_ZERO:  rd_data = '0;
      SRC_WRITE: rd_data = wr_data;
      default:   rd_data = stored;
    endcase
  end

  // R4: a live write to the port's register is forwarded this cycle
  a_r4_forward: assert property (@(posedge clk) disable iff (rst)
    (wr_live && rd_addr == wr_addr && rd_addr != '0) |-> (rd_data == wr_data));

  // R5: register 0 reads as zero whatever the write port does
  a_r5_zero_read: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == '0) |-> (rd_data == '0));

  // R7: without a live write the port shows the stored contents
  a_r7_no_forward: assert property (@(posedge clk) disable iff (rst)
    (!wr_live && rd_addr != '0) |-> (rd_data == stored));
endmodule

// File: rtl/regfile_bypass.sv
module regfile_bypass
  import rf_pkg::*;
#(
  parameter int DEPTH  = RF_DEPTH_DEF,
  parameter int DATA_W = RF_DATA_W_DEF,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int NRD    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_a_addr,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [ADDR_W-1:0] rd_b_addr,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wb_en,
  input  logic [ADDR_W-1:0] wb_addr,
  input  logic [DATA_W-1:0] wb_data
);
  // A write is live only if enabled, outside reset, and not aimed at register 0
  logic wr_live;
  assign wr_live = wb_en && !rst && (wb_addr != '0);

  logic [NRD*ADDR_W-1:0] addr_vec;
  logic [NRD*DATA_W-1:0] stored_vec;
  logic [NRD*DATA_W-1:0] out_vec;

  assign addr_vec = {rd_b_addr, rd_a_addr};

  rf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .NRD(NRD)) u_store (
    .clk     (clk),
    .wr_en   (wr_live),
    .wr_addr (wb_addr),
    .wr_data (wb_data),
    .rd_addr (addr_vec),
    .rd_data (stored_vec)
  );

  for (genvar p = 0; p < NRD; p++) begin : g_port
    rf_bypass #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_byp (
      .clk     (clk),
      .rst     (rst),
      .rd_addr (addr_vec[p*ADDR_W +: ADDR_W]),
      .stored  (stored_vec[p*DATA_W +: DATA_W]),
      .wr_live (wr_live),
      .wr_addr (wb_addr),
      .wr_data (wb_data),
      .rd_data (out_vec[p*DATA_W +: DATA_W])
    );
  end

  assign rd_a_data = out_vec[0 +: DATA_W];
  assign rd_b_data = out_vec[DATA_W +: DATA_W];

  // R3: a committed write is visible one cycle later on port A when no
  // newer write to the same register is forwarded
  a_r3_commit: assert property (@(posedge clk) disable iff (rst)
    (wb_en && wb_addr != '0) |=>
      (!(rd_a_addr == $past(wb_addr) && !(wb_en && wb_addr == rd_a_addr))
       || rd_a_data == $past(wb_data)));

  // R6: both ports see the same value when they name the same register
  a_r6_ports_agree: assert property (@(posedge clk) disable iff (rst)
    (rd_a_addr == rd_b_addr) |-> (rd_a_data == rd_b_data));
endmodule

// File: tb/sim_regfile_bypass.sv
module sim_regfile_bypass;
  localparam int AW = 5;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] ra, rb, wa;
  logic [DW-1:0] da, db, wd;
  logic          we;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  regfile_bypass u0 (
    .clk(clk), .rst(rst),
    .rd_a_addr(ra), .rd_a_data(da),
    .rd_b_addr(rb), .rd_b_data(db),
    .wb_en(we), .wb_addr(wa), .wb_data(wd)
  );

  // {we, waddr, wdata, ra, rb, expect_a, expect_b}; the comment names the requirement
  typedef struct packed {
    logic          we;
    logic [AW-1:0] wa;
    logic [DW-1:0] wd;
    logic [AW-1:0] ra;
    logic [AW-1:0] rb;
    logic [DW-1:0] ea;
    logic [DW-1:0] eb;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VT [NV] = '{
    '{1'b1, 5'd5,  32'h0000_00A1, 5'd5,  5'd0,  32'h0000_00A1, 32'h0},        // R4 forward, R5
    '{1'b0, 5'd5,  32'h0000_00FF, 5'd5,  5'd0,  32'h0000_00A1, 32'h0},        // R3 stored, R7
    '{1'b1, 5'd0,  32'hDEAD_BEEF, 5'd0,  5'd0,  32'h0,         32'h0},        // R5 no forward of reg 0
    '{1'b1, 5'd7,  32'h0000_00B2, 5'd7,  5'd7,  32'h0000_00B2, 32'h0000_00B2},// R6 both forward
    '{1'b1, 5'd9,  32'h0000_00C3, 5'd5,  5'd7,  32'h0000_00A1, 32'h0000_00B2},// R2 no match
    '{1'b1, 5'd31, 32'h0000_00D4, 5'd31, 5'd9,  32'h0000_00D4, 32'h0000_00C3},// R9 top forward, R6
    '{1'b0, 5'd9,  32'h0,         5'd9,  5'd31, 32'h0000_00C3, 32'h0000_00D4},// R9 top stored
    '{1'b1, 5'd5,  32'h0000_00E5, 5'd5,  5'd5,  32'h0000_00E5, 32'h0000_00E5},// R4 overwrite
    '{1'b0, 5'd3,  32'h0,         5'd5,  5'd0,  32'h0000_00E5, 32'h0},        // R5 reg 0 still zero
    '{1'b0, 5'd9,  32'h0000_0123, 5'd9,  5'd7,  32'h0000_00C3, 32'h0000_00B2} // R7 match, enable low
  };

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [AW-1:0] x, input logic [AW-1:0] y);
    we = w; wa = a; wd = d; ra = x; rb = y;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    drive(1'b0, '0, '0, '0, '0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    #2;
    check("R5 reset port A", da, 32'h0);
    check("R5 reset port B", db, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VT[i].we, VT[i].wa, VT[i].wd, VT[i].ra, VT[i].rb);
      #2;
      check($sformatf("R2/R4/R6 vector %0d port A", i), da, VT[i].ea);
      check($sformatf("R2/R4/R6 vector %0d port B", i), db, VT[i].eb);
    end

    // R1 R9: registers 30 and 31 are separate
    @(negedge clk);
    drive(1'b1, 5'd30, 32'h3030_3030, 5'd31, 5'd30);
    #2;
    check("R9 reg31 beside forwarded reg30", da, 32'h0000_00D4);
    check("R1 reg30 forwarded", db, 32'h3030_3030);
    @(negedge clk);
    drive(1'b0, 5'd0, '0, 5'd30, 5'd31);
    #2;
    check("R1 reg30 stored", da, 32'h3030_3030);
    check("R9 reg31 stored", db, 32'h0000_00D4);

    // R8: write during reset is neither forwarded nor stored
    @(negedge clk);
    drive(1'b1, 5'd3, 32'h0000_0011, 5'd4, 5'd4);
    @(negedge clk);
    rst = 1'b1;
    drive(1'b1, 5'd3, 32'h0000_0077, 5'd3, 5'd5);
    #2;
    check("R8 no forward in reset", da, 32'h0000_0011);
    check("R8 value kept in reset", db, 32'h0000_00E5);
    @(negedge clk);
    rst = 1'b0;
    drive(1'b0, 5'd0, '0, 5'd3, 5'd7);
    #2;
    check("R8 write in reset dropped", da, 32'h0000_0011);
    check("R8 reg7 kept through reset", db, 32'h0000_00B2);

    // R7: enable low, matching address, then confirm nothing stored
    @(negedge clk);
    drive(1'b0, 5'd3, 32'hFFFF_FFFF, 5'd3, 5'd3);
    #2;
    check("R7 no forward enable low", da, 32'h0000_0011);
    @(negedge clk);
    drive(1'b0, 5'd0, '0, 5'd3, 5'd0);
    #2;
    check("R7 no store enable low", da, 32'h0000_0011);
    check("R5 reg0 after writes", db, 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule